// File: doc/BRIEF.md
# PC-Indexed Stride Prefetch Engine

This block watches a stream of demand-miss requests and learns, per instruction address, the distance between consecutive cache blocks that the instruction touches. Each request carries a byte address, an instruction address with a qualifier bit, and a context number. The engine holds a small fully associative table keyed by instruction address. Each entry keeps the last block address it saw, the last block-to-block distance, and a saturating confidence count.

When an instruction repeats the same nonzero distance, its confidence rises. Once confidence is positive, every further request from that instruction starts a burst of predicted block addresses. The burst leaves the block one address per accepted handshake. It may be cut short where a prediction would leave the page of the triggering block, and in that case a running counter records how many predictions were dropped. New instructions displace the least confident entry. While a burst is being sent, the request side stalls.

Top module: `stride_pf_engine`

## Requirements
- R1: A request accepted with `req_pc_valid` low changes nothing: no prefetch is emitted, the span counter holds, and no table entry is created or trained, so later requests behave as if it never arrived.
- R2: The byte address is rounded down to a multiple of `BLK_BYTES` by clearing its low log2(`BLK_BYTES`) bits before any distance is computed, so offsets inside a block have no effect.
- R3: With `CTX_SEP` = 1, each value of `req_ctx` selects its own table and the same instruction address trains independently in each context; with `CTX_SEP` = 0 all requests share table 0.
- R4: On a table hit, the distance is the aligned address minus the entry's last address (modulo 2^`AW`). If it equals the stored distance and is nonzero, confidence rises by one and stops at `CONF_MAX`.
- R5: On a hit with a changed or zero distance, the new distance replaces the stored one and confidence becomes 0. On every hit the last address becomes the current aligned address, and no prefetch follows when the resulting confidence is 0.
- R6: On a hit with positive resulting confidence, the engine emits block + d×distance for d = 1, 2, … `DEGREE`, in increasing d, one per cycle in which `pf_valid` and `pf_ready` are both high.
- R7: With `PAGE_STOP` = 1, the burst ends at the first candidate whose bits above log2(`PAGE_BYTES`) differ from those of the triggering block. That candidate and all later ones are not emitted, and `span_count` grows by `DEGREE` − d + 1.
- R8: A table miss never emits a prefetch. It writes a new entry holding the instruction address, the aligned address, distance 0 and confidence 0, using the lowest-numbered free slot.
- R9: On a miss with all `DEPTH` entries in use, the entry with the smallest confidence is replaced, and the earliest-inserted of equally confident entries is chosen.
- R10: `req_ready` is low from the cycle after a burst starts until its last address has been taken, and `pf_addr` holds steady while `pf_valid` is high and `pf_ready` is low.
- R11: A synchronous reset empties the table, clears `span_count`, and leaves `pf_valid` low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Demand-miss request present |
| req_ready | output | 1 | Engine can take a request (low during a burst) |
| req_addr | input | AW | Byte address of the miss |
| req_pc_valid | input | 1 | Instruction address is meaningful |
| req_pc | input | AW | Instruction address that caused the miss |
| req_ctx | input | CTXW | Context number (CTXW = max(1, log2(NUM_CTX))) |
| pf_valid | output | 1 | Prefetch block address available |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | AW | Predicted block address |
| span_count | output | SPAN_W | Running count of predictions dropped at page boundaries |

## Verification
Two functions can act on the same edge: training an entry and cutting the burst at a page boundary both happen when the request that hits is accepted. When the very first candidate already leaves the page, the table update and the `span_count` increase of `DEGREE` happen together and no burst starts. The bench provokes this with large distances and with trigger blocks placed near page edges. It runs a sweep of positive and negative distances and judges each request against an arithmetic model of the table, comparing every emitted address, the burst length, the span count and the next request's outcome. A stalling `pf_ready` pattern is mixed into the same sweep, so that holding an address and accepting the next request are both tested against the end of each burst.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

   // true when v is a positive power of two
   function automatic bit f_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // log2 with a floor of one bit, for index widths
   function automatic int f_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pf_victim_sel.sv
module pf_victim_sel
   import stride_pf_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int CONF_W = 2,
   localparam int IW    = f_idx_w(DEPTH)
)(
   input  logic [DEPTH-1:0]             valid_v,
   input  logic [DEPTH-1:0][CONF_W-1:0] conf_v,
   input  logic [DEPTH-1:0][IW-1:0]     rank_v,
   output logic                         full,
   output logic [IW-1:0]                slot,
   output logic [IW-1:0]                slot_rank,
   output logic [IW-1:0]                evict_rank
);

   logic [IW-1:0] best;
   logic [IW-1:0] free_idx;
   logic          free_found;
   logic [IW:0]   used_cnt;

   // least confident entry, earliest rank on ties
   always_comb begin
      best = '0;
      for (int i = 1; i < DEPTH; i++) begin
         if ((conf_v[i] < conf_v[best]) ||
             ((conf_v[i] == conf_v[best]) && (rank_v[i] < rank_v[best])))
            best = IW'(i);
      end
   end

   // lowest free slot and occupancy
   always_comb begin
      free_idx   = '0;
      free_found = 1'b0;
      used_cnt   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!free_found && !valid_v[i]) begin
            free_idx   = IW'(i);
            free_found = 1'b1;
         end
         if (valid_v[i])
            used_cnt = used_cnt + 1'b1;
      end
   end

   assign full       = &valid_v;
   assign slot       = full ? best : free_idx;
   assign slot_rank  = full ? IW'(DEPTH - 1) : used_cnt[IW-1:0];
   assign evict_rank = rank_v[best];

endmodule

// File: rtl/pf_ctx_table.sv
module pf_ctx_table
   import stride_pf_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DEPTH    = 16,
   parameter int CONF_W   = 2,
   parameter int CONF_MAX = 3,
   localparam int IW      = f_idx_w(DEPTH)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              upd,
   input  logic [AW-1:0]     pc,
   input  logic [AW-1:0]     blk,
   output logic              hit,
   output logic [AW-1:0]     stride_new,
   output logic [CONF_W-1:0] conf_new
);

   logic [DEPTH-1:0]             ent_v;
   logic [DEPTH-1:0][AW-1:0]     ent_pc;
   logic [DEPTH-1:0][AW-1:0]     ent_last;
   logic [DEPTH-1:0][AW-1:0]     ent_str;
   logic [DEPTH-1:0][CONF_W-1:0] ent_conf;
   logic [DEPTH-1:0][IW-1:0]     ent_rank;

   logic [DEPTH-1:0] hit_v;
   logic [IW-1:0]    hit_idx;
   logic             same_dist;
   logic             full;
   logic [IW-1:0]    slot;
   logic [IW-1:0]    slot_rank;
   logic [IW-1:0]    evict_rank;

   // tag compare for every entry
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_v[g] = ent_v[g] && (ent_pc[g] == pc);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < DEPTH; i++)
         if (hit_v[i]) hit_idx = IW'(i);
   end

   assign hit        = |hit_v;
   assign stride_new = blk - ent_last[hit_idx];
   assign same_dist  = (stride_new == ent_str[hit_idx]) && (|stride_new);

   always_comb begin
      if (!same_dist)
         conf_new = '0;
      else if (ent_conf[hit_idx] >= CONF_W'(CONF_MAX))
         conf_new = CONF_W'(CONF_MAX);
      else
         conf_new = ent_conf[hit_idx] + 1'b1;
   end

   pf_victim_sel #(
      .DEPTH  (DEPTH),
      .CONF_W (CONF_W)
   ) u_vsel (
      .valid_v    (ent_v),
      .conf_v     (ent_conf),
      .rank_v     (ent_rank),
      .full       (full),
      .slot       (slot),
      .slot_rank  (slot_rank),
      .evict_rank (evict_rank)
   );

   // valid bits and insertion ranks
   always_ff @(posedge clk) begin
      if (rst) begin
         ent_v    <= '0;
         ent_rank <= '0;
      end else if (upd && !hit) begin
         if (full) begin
            for (int i = 0; i < DEPTH; i++)
               if (ent_rank[i] > evict_rank)
                  ent_rank[i] <= ent_rank[i] - 1'b1;
         end
         ent_v[slot]    <= 1'b1;
         ent_rank[slot] <= slot_rank;
      end
   end

   // entry payload
   always_ff @(posedge clk) begin
      if (upd) begin
         if (hit) begin
            ent_last[hit_idx] <= blk;
            ent_str[hit_idx]  <= stride_new;
            ent_conf[hit_idx] <= conf_new;
         end else begin
            ent_pc[slot]   <= pc;
            ent_last[slot] <= blk;
            ent_str[slot]  <= '0;
            ent_conf[slot] <= '0;
         end
      end
   end

endmodule

// File: rtl/pf_burst.sv
module pf_burst
   import stride_pf_pkg::*;
#(
   parameter int AW         = 32,
   parameter int PAGE_BYTES = 4096,
   parameter int DEGREE     = 4,
   parameter bit PAGE_STOP  = 1'b1,
   parameter int SPAN_W     = 16,
   localparam int PG_LOG    = $clog2(PAGE_BYTES),
   localparam int DW        = f_idx_w(DEGREE + 1)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              trig,
   input  logic [AW-1:0]     trig_blk,
   input  logic [AW-1:0]     trig_stride,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [AW-1:0]     out_addr,
   output logic [SPAN_W-1:0] span
);

   logic              busy;
   logic [AW-1:0]     cur;
   logic [AW-1:0]     step;
   logic [AW-1:0]     base_pg;
   logic [DW-1:0]     d_cnt;

   logic [AW-1:0] first_cand;
   logic [AW-1:0] next_cand;
   logic          first_cross;
   logic          next_cross;

   assign first_cand = trig_blk + trig_stride;
   assign next_cand  = cur + step;

   if (PAGE_STOP) begin : g_pgstop
      assign first_cross = (first_cand >> PG_LOG) != (trig_blk >> PG_LOG);
      assign next_cross  = (next_cand  >> PG_LOG) != base_pg;
   end else begin : g_nostop
      assign first_cross = 1'b0;
      assign next_cross  = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         cur     <= '0;
         step    <= '0;
         base_pg <= '0;
         d_cnt   <= '0;
         span    <= '0;
      end else if (!busy) begin
         if (trig) begin
            step    <= trig_stride;
            base_pg <= trig_blk >> PG_LOG;
            if (first_cross) begin
               span <= span + SPAN_W'(DEGREE);
            end else begin
               busy  <= 1'b1;
               cur   <= first_cand;
               d_cnt <= DW'(1);
            end
         end
      end else if (out_ready) begin
         if (d_cnt == DW'(DEGREE)) begin
            busy <= 1'b0;
         end else if (next_cross) begin
            busy <= 1'b0;
            span <= span + SPAN_W'(DEGREE) - SPAN_W'(d_cnt);
         end else begin
            cur   <= next_cand;
            d_cnt <= d_cnt + 1'b1;
         end
      end
   end

   assign out_valid = busy;
   assign out_addr  = cur;

endmodule

// File: rtl/stride_pf_engine.sv
module stride_pf_engine
   import stride_pf_pkg::*;
#(
   parameter int AW         = 32,
   parameter int BLK_BYTES  = 64,
   parameter int PAGE_BYTES = 4096,
   parameter int DEPTH      = 16,
   parameter int DEGREE     = 4,
   parameter int CONF_W     = 2,
   parameter int CONF_MAX   = 3,
   parameter int NUM_CTX    = 2,
   parameter bit CTX_SEP    = 1'b1,
   parameter bit PAGE_STOP  = 1'b1,
   parameter int SPAN_W     = 16,
   localparam int CTXW      = f_idx_w(NUM_CTX),
   localparam int NTAB      = CTX_SEP ? NUM_CTX : 1,
   localparam int TW        = f_idx_w(NTAB)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_addr,
   input  logic              req_pc_valid,
   input  logic [AW-1:0]     req_pc,
   input  logic [CTXW-1:0]   req_ctx,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [AW-1:0]     pf_addr,
   output logic [SPAN_W-1:0] span_count
);

   // elaboration-time parameter checks
   if (!f_is_pow2(BLK_BYTES)) begin : g_chk_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (!f_is_pow2(PAGE_BYTES) || PAGE_BYTES < BLK_BYTES) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two not below BLK_BYTES");
   end
   if (DEPTH < 2) begin : g_chk_depth
      $error("DEPTH must be at least 2");
   end
   if (DEGREE < 1) begin : g_chk_deg
      $error("DEGREE must be at least 1");
   end
   if (CONF_MAX < 1 || CONF_MAX > (1 << CONF_W) - 1) begin : g_chk_conf
      $error("CONF_MAX must fit in CONF_W bits and be positive");
   end
   if (!f_is_pow2(NUM_CTX)) begin : g_chk_ctx
      $error("NUM_CTX must be a power of two");
   end

   logic              acc;
   logic              burst_on;
   logic [AW-1:0]     blk_addr;
   logic [TW-1:0]     tsel;
   logic              lk_hit;
   logic              trig;

   logic [NTAB-1:0]             t_hit;
   logic [NTAB-1:0][AW-1:0]     t_stride;
   logic [NTAB-1:0][CONF_W-1:0] t_conf;

   assign acc      = req_valid && req_ready;
   assign blk_addr = req_addr & ~AW'(BLK_BYTES - 1);

   if (CTX_SEP) begin : g_ctx_sel
      assign tsel = TW'(req_ctx);
   end else begin : g_ctx_one
      assign tsel = '0;
   end

   for (genvar t = 0; t < NTAB; t++) begin : g_tab
      pf_ctx_table #(
         .AW       (AW),
         .DEPTH    (DEPTH),
         .CONF_W   (CONF_W),
         .CONF_MAX (CONF_MAX)
      ) u_tab (
         .clk        (clk),
         .rst        (rst),
         .upd        (acc && req_pc_valid && (tsel == TW'(t))),
         .pc         (req_pc),
         .blk        (blk_addr),
         .hit        (t_hit[t]),
         .stride_new (t_stride[t]),
         .conf_new   (t_conf[t])
      );
   end

   assign lk_hit = t_hit[tsel];
   assign trig   = acc && req_pc_valid && lk_hit && (|t_conf[tsel]);

   pf_burst #(
      .AW         (AW),
      .PAGE_BYTES (PAGE_BYTES),
      .DEGREE     (DEGREE),
      .PAGE_STOP  (PAGE_STOP),
      .SPAN_W     (SPAN_W)
   ) u_burst (
      .clk         (clk),
      .rst         (rst),
      .trig        (trig),
      .trig_blk    (blk_addr),
      .trig_stride (t_stride[tsel]),
      .out_ready   (pf_ready),
      .out_valid   (burst_on),
      .out_addr    (pf_addr),
      .span        (span_count)
   );

   assign pf_valid  = burst_on;
   assign req_ready = !burst_on;

endmodule

// File: rtl/stride_pf_checker.sv
module stride_pf_checker #(
   parameter int AW     = 32,
   parameter int SPAN_W = 16
)(
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_pc_valid,
   input logic              lk_hit,
   input logic              pf_valid,
   input logic              pf_ready,
   input logic [AW-1:0]     pf_addr,
   input logic [SPAN_W-1:0] span_count
);

   // R10: request side closed while a burst is pending
   a_r10_closed_in_burst: assert property (@(posedge clk) disable iff (rst)
      pf_valid |-> !req_ready);

   // R10: stalled prefetch address does not move
   a_r10_hold_addr: assert property (@(posedge clk) disable iff (rst)
      pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

   // R1: request without instruction address leaves outputs quiet
   a_r1_no_pc_quiet: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_ready && !req_pc_valid |=> !pf_valid && $stable(span_count));

   // R8: table miss starts nothing
   a_r8_miss_quiet: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_ready && req_pc_valid && !lk_hit |=> !pf_valid && $stable(span_count));

   // R7: span count moves only on an accepted request or a taken prefetch
   a_r7_span_source: assert property (@(posedge clk) disable iff (rst)
      !(req_valid && req_ready) && !(pf_valid && pf_ready) |=> $stable(span_count));

endmodule

bind stride_pf_engine stride_pf_checker #(
   .AW     (AW),
   .SPAN_W (SPAN_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_pc_valid (req_pc_valid),
   .lk_hit       (lk_hit),
   .pf_valid     (pf_valid),
   .pf_ready     (pf_ready),
   .pf_addr      (pf_addr),
   .span_count   (span_count)
);

// File: tb/sim_stride_pf_engine.sv
`timescale 1ns/1ps
module sim_stride_pf_engine;

   localparam int AW    = 32;
   localparam int DEP   = 4;
   localparam int DEG   = 4;
   localparam int CMAX  = 3;
   localparam int NCTX  = 2;
   localparam int SW    = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_pc_valid = 1'b0;
   logic [AW-1:0] req_pc = '0;
   logic [0:0]    req_ctx = '0;
   logic          pf_valid;
   logic          pf_ready = 1'b1;
   logic [AW-1:0] pf_addr;
   logic [SW-1:0] span_count;

   always #5 clk = ~clk;

   stride_pf_engine #(
      .AW (AW), .BLK_BYTES (64), .PAGE_BYTES (4096), .DEPTH (DEP),
      .DEGREE (DEG), .CONF_W (2), .CONF_MAX (CMAX), .NUM_CTX (NCTX),
      .CTX_SEP (1'b1), .PAGE_STOP (1'b1), .SPAN_W (SW)
   ) u0 (
      .clk (clk), .rst (rst), .req_valid (req_valid), .req_ready (req_ready),
      .req_addr (req_addr), .req_pc_valid (req_pc_valid), .req_pc (req_pc),
      .req_ctx (req_ctx), .pf_valid (pf_valid), .pf_ready (pf_ready),
      .pf_addr (pf_addr), .span_count (span_count)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit stall_en = 1'b0;
   int stall_ctr = 0;

   // arithmetic model of the table
   bit          m_v    [NCTX][DEP];
   logic [31:0] m_pc   [NCTX][DEP];
   logic [31:0] m_last [NCTX][DEP];
   logic [31:0] m_str  [NCTX][DEP];
   int          m_conf [NCTX][DEP];
   int          m_rank [NCTX][DEP];
   int          m_span;
   logic [31:0] exp_q  [DEG];
   int          exp_n;

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL R10 watchdog cycles=%0d expected below %0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < NCTX; c++)
         for (int i = 0; i < DEP; i++) begin
            m_v[c][i] = 1'b0; m_rank[c][i] = 0; m_conf[c][i] = 0;
         end
      m_span = 0;
   endtask

   task automatic model_step(input logic [31:0] a, input bit pcv,
                             input logic [31:0] pc, input int ctx);
      logic [31:0] blk, ns, cand;
      int hi, used, slot, best;
      exp_n = 0;
      if (!pcv) return;
      blk = a & ~32'd63;
      hi = -1; used = 0;
      for (int i = 0; i < DEP; i++) begin
         if (m_v[ctx][i] && m_pc[ctx][i] == pc) hi = i;
         if (m_v[ctx][i]) used++;
      end
      if (hi >= 0) begin
         ns = blk - m_last[ctx][hi];
         if (ns == m_str[ctx][hi] && ns != 0) begin
            if (m_conf[ctx][hi] < CMAX) m_conf[ctx][hi]++;
         end else begin
            m_str[ctx][hi] = ns;
            m_conf[ctx][hi] = 0;
         end
         m_last[ctx][hi] = blk;
         if (m_conf[ctx][hi] > 0) begin
            for (int d = 1; d <= DEG; d++) begin
               cand = blk + 32'(d) * ns;
               if ((cand >> 12) != (blk >> 12)) begin
                  m_span += DEG - d + 1;
                  break;
               end
               exp_q[exp_n] = cand;
               exp_n++;
            end
         end
      end else begin
         if (used == DEP) begin
            best = 0;
            for (int i = 1; i < DEP; i++)
               if (m_conf[ctx][i] < m_conf[ctx][best] ||
                   (m_conf[ctx][i] == m_conf[ctx][best] && m_rank[ctx][i] < m_rank[ctx][best]))
                  best = i;
            for (int i = 0; i < DEP; i++)
               if (m_rank[ctx][i] > m_rank[ctx][best]) m_rank[ctx][i]--;
            slot = best;
            m_rank[ctx][slot] = DEP - 1;
         end else begin
            slot = -1;
            for (int i = 0; i < DEP; i++)
               if (slot < 0 && !m_v[ctx][i]) slot = i;
            m_rank[ctx][slot] = used;
         end
         m_v[ctx][slot] = 1'b1;
         m_pc[ctx][slot] = pc;
         m_last[ctx][slot] = blk;
         m_str[ctx][slot] = '0;
         m_conf[ctx][slot] = 0;
      end
   endtask

   // called at a falling edge; returns at a falling edge with the engine idle
   task automatic do_req(input logic [31:0] a, input bit pcv, input logic [31:0] pc,
                         input int ctx, input string tag);
      int k, guard;
      model_step(a, pcv, pc, ctx);
      check(req_ready === 1'b1, "R10", "ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_addr = a; req_pc_valid = pcv; req_pc = pc; req_ctx = 1'(ctx);
      @(negedge clk);
      req_valid = 1'b0;
      k = 0; guard = 0;
      while (pf_valid === 1'b1 && guard < 64) begin
         if (k < exp_n)
            check(pf_addr === exp_q[k], tag, "prefetch address", pf_addr, exp_q[k]);
         else
            check(1'b0, tag, "extra prefetch", pf_addr, 32'(exp_n));
         check(req_ready === 1'b0, "R10", "ready during burst", 32'(req_ready), 32'd0);
         pf_ready = stall_en ? ((stall_ctr % 3) != 2) : 1'b1;
         stall_ctr++;
         if (pf_ready) k++;
         @(negedge clk);
         guard++;
      end
      pf_ready = 1'b1;
      check(k == exp_n, tag, "burst length", 32'(k), 32'(exp_n));
      check(span_count === 16'(m_span), "R7", "span count", 32'(span_count), 32'(m_span));
   endtask

   task automatic apply_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
      check(req_ready === 1'b1, "R11", "ready after reset", 32'(req_ready), 32'd1);
      check(pf_valid === 1'b0, "R11", "pf_valid after reset", 32'(pf_valid), 32'd0);
      check(span_count === '0, "R11", "span after reset", 32'(span_count), 32'd0);
   endtask

   initial begin
      logic [31:0] strides [9];
      strides = '{32'd64, -32'sd64, 32'd128, -32'sd128, 32'd192,
                  32'd448, -32'sd320, 32'd4096, 32'd1024};
      @(negedge clk);
      apply_reset();

      // R2 R4 R6: steady +1 block stride with offsets inside each block
      for (int j = 0; j < 7; j++)
         do_req(32'h0000_2000 + 32'(j * 64) + 32'((j * 23) % 64), 1'b1, 32'h400, 0, "R4");

      // R1: request without a valid instruction address, then training continues
      do_req(32'h0000_9A37, 1'b0, 32'h400, 0, "R1");
      do_req(32'h0000_21C5, 1'b1, 32'h400, 0, "R1");

      // R5: change of stride then repeated block (zero stride)
      do_req(32'h0000_2400, 1'b1, 32'h400, 0, "R5");
      do_req(32'h0000_2410, 1'b1, 32'h400, 0, "R5");
      do_req(32'h0000_243F, 1'b1, 32'h400, 0, "R5");

      // R3: same instruction address in both contexts with different strides
      for (int j = 0; j < 5; j++) begin
         do_req(32'h0004_0000 + 32'(j * 128), 1'b1, 32'h777, 0, "R3");
         do_req(32'h0005_0F00 - 32'(j * 64), 1'b1, 32'h777, 1, "R3");
      end

      // R6 R7 R8 R10: sweep of strides, positions and stall patterns
      for (int c = 0; c < NCTX; c++)
         for (int s = 0; s < 9; s++) begin
            stall_en = (s % 2) == 1;
            for (int j = 0; j < 7; j++)
               do_req(32'(32'h0010_0000 * (s + 1)) + 32'h0000_0A00 + 32'(j) * strides[s]
                      + 32'((j * 13) % 64), 1'b1, 32'h1000 + 32'(s * 4), c, "R6");
         end
      stall_en = 1'b0;

      // R9: eviction of least confident, oldest on ties
      apply_reset();
      for (int j = 0; j < 4; j++) do_req(32'h0002_0000 + 32'(j * 64), 1'b1, 32'hA0, 0, "R9");
      do_req(32'h0003_0000, 1'b1, 32'hB0, 0, "R8");
      do_req(32'h0004_0000, 1'b1, 32'hC0, 0, "R8");
      for (int j = 0; j < 3; j++) do_req(32'h0005_0000 + 32'(j * 128), 1'b1, 32'hD0, 0, "R9");
      do_req(32'h0006_0000, 1'b1, 32'hE0, 0, "R9");
      for (int j = 1; j < 4; j++) do_req(32'h0003_0000 + 32'(j * 64), 1'b1, 32'hB0, 0, "R9");
      for (int j = 1; j < 4; j++) do_req(32'h0004_0000 + 32'(j * 64), 1'b1, 32'hC0, 0, "R9");
      do_req(32'h0002_0100, 1'b1, 32'hA0, 0, "R9");
      do_req(32'h0005_0180, 1'b1, 32'hD0, 0, "R9");

      // R7: trigger next to page end so the first candidate already crosses
      for (int j = 0; j < 4; j++) do_req(32'h0007_0F00 + 32'(j * 64), 1'b1, 32'hF0, 1, "R7");

      summary();
      $finish;
   end

endmodule